// File: doc/BRIEF.md
# Two-Strobe Transmit Word Queue

This block holds up to eight transmit words of 31 bits each. A serializer downstream takes them in the order they were loaded. The host reaches the block over a 16-bit bus. It builds each word with two strobes, which must come in a fixed order. The low strobe captures the lower sixteen bits of the word in a holding register. The high strobe supplies the upper fifteen bits and commits the assembled word to the next free slot in the same clock edge.

The serializer sees the oldest stored word on a head output. A flag shows that a word is waiting, and a one-cycle pop removes the word. A word counter tracks the loaded words that have not yet been taken. The ready flag is high exactly when that counter is zero, which means every loaded word has gone out. Loading and popping run independently and share only the occupancy state. A commit made while all slots are full is dropped without a trace.

Top module: `tx_word_queue`

## Requirements
- R1: After a synchronous active-low reset, `ready` is 1, `word_count` is 0, `word_avail` is 0 and `head_word` is 0. No low-part is held, so a high strobe in the first cycle after reset is ignored.
- R2: A committed word is `{high-strobe bus[14:0], low-strobe bus[15:0]}`, with the low-strobe value in word bits [15:0]. Bus bit 15 during the high strobe is discarded.
- R3: Committed words leave through `head_word` in the order they were committed. A commit takes effect at the clock edge that samples the high strobe.
- R4: When `word_count` is 8, a commit without a same-cycle pop is ignored. The count stays at 8 and the eight stored words come out unchanged.
- R5: A high strobe is ignored if no low strobe has come since the last high strobe or since reset.
- R6: `ready` is high exactly when `word_count` is 0. It falls one cycle after the first commit and rises one cycle after the pop that removes the last word.
- R7: `word_count` goes up by one for each accepted commit and down by one for each pop while a word is available. A pop while `word_avail` is 0 has no effect.
- R8: A pop and an accepted commit in the same cycle, with the queue neither empty nor full, leave `word_count` unchanged. The popped word leaves, and the new word joins the tail.
- R9: When several low strobes come before one high strobe, the commit uses the last low-strobe value. If both strobes come in the same cycle, the high strobe pairs with the low part held before that cycle, and the new low part is then held for the next high strobe.
- R10: `word_avail` is the inverse of `ready`. While `word_avail` is 1 and no pop is issued, `head_word` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_lo | input | 1 | Strobe that captures the low part of a word |
| load_hi | input | 1 | Strobe that supplies the high part and commits the word |
| bus_data | input | 16 | Host data bus |
| pop | input | 1 | Serializer takes the head word |
| head_word | output | 31 | Oldest stored word |
| word_avail | output | 1 | At least one word is stored |
| ready | output | 1 | Every loaded word has been taken |
| word_count | output | 4 | Number of stored words |

## Verification
The bench builds the block with its default parameters: a 31-bit word, a 16-bit bus and a depth of eight. With these values the full condition comes after eight commits, and the write and read pointers wrap many times during a few thousand random cycles. The 15-bit high part means a set bus bit 15 on the high strobe can be seen to be dropped. Directed cases cover these situations:
- a high strobe with no preceding low strobe, after reset and after a commit
- a ninth commit into a full queue
- repeated low strobes before one high strobe
- a pop and a commit in the same cycle

Random mixes of strobes and pops, including both strobes in one cycle, are then compared each cycle against a reference queue kept in the bench.

// File: rtl/txq_pkg.sv
// Package: helpers shared by the transmit word queue modules.
// Assumes depths of at least one entry.
package txq_pkg;

    // Width of an index into a storage of the given depth, at least one bit.
    function automatic int idx_bits(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

    // Width of a counter that must reach the given depth inclusive.
    function automatic int cnt_bits(input int depth);
        return $clog2(depth + 1);
    endfunction

endpackage

// File: rtl/txq_assembler.sv
// Module: txq_assembler
// Builds a word from two ordered strobes. The low strobe captures the
// whole bus into a holding register. The high strobe, when a low part is
// held, raises a commit request and presents the full word in the same
// cycle. A high strobe with no low part held is ignored.
// Assumes WORD_W > BUS_W and WORD_W - BUS_W <= BUS_W.
module txq_assembler #(
    parameter int WORD_W = 31,
    parameter int BUS_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_lo,
    input  logic              load_hi,
    input  logic [BUS_W-1:0]  bus_data,
    output logic              lo_held,
    output logic              commit_req,
    output logic [WORD_W-1:0] commit_word
);
    localparam int HI_W = WORD_W - BUS_W;

    logic [BUS_W-1:0] lo_q;

    // Capture the low part, and track whether one waits for its high part.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q    <= '0;
            lo_held <= 1'b0;
        end else begin
            if (load_lo) begin
                lo_q    <= bus_data;
                lo_held <= 1'b1;
            end else if (load_hi) begin
                lo_held <= 1'b0;
            end
        end
    end

    // A high strobe completes the word only when a low part is held.
    always_comb begin
        commit_req  = load_hi && lo_held;
        commit_word = {bus_data[HI_W-1:0], lo_q};
    end
endmodule

// File: rtl/txq_store.sv
// Module: txq_store
// Circular storage of DEPTH words with one write and one read pointer.
// The head word is read combinationally at the read pointer.
// Assumes the caller never writes when full or reads when empty.
module txq_store
    import txq_pkg::*;
#(
    parameter int WORD_W = 31,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_word
);
    localparam int PTR_W = idx_bits(DEPTH);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic [WORD_W-1:0] slot [DEPTH];

    // Advance the pointers, wrapping after the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_en) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (rd_en) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        // Each slot loads the incoming word when the write pointer selects it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot[i] <= '0;
            end else if (wr_en && (wr_ptr == PTR_W'(i))) begin
                slot[i] <= wr_word;
            end
        end
    end

    // Present the oldest word.
    always_comb rd_word = slot[rd_ptr];
endmodule

// File: rtl/txq_count.sv
// Module: txq_count
// Counter of stored words, with the empty and full conditions derived
// from it. Increment and decrement in the same cycle cancel.
// Assumes the caller gates inc with not-full and dec with not-empty.
module txq_count
    import txq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       inc,
    input  logic                       dec,
    output logic [cnt_bits(DEPTH)-1:0] count,
    output logic                       empty,
    output logic                       full
);
    localparam int CNT_W = cnt_bits(DEPTH);

    // Track the number of words loaded but not yet taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc && !dec) begin
            count <= count + 1'b1;
        end else if (dec && !inc) begin
            count <= count - 1'b1;
        end
    end

    // Derive the occupancy conditions.
    always_comb begin
        empty = (count == '0);
        full  = (count == CNT_W'(DEPTH));
    end
endmodule

// File: rtl/tx_word_queue.sv
// Module: tx_word_queue
// Transmit word queue loaded by two ordered bus strobes and drained by a
// serializer through a head/pop interface. A commit into a full queue
// and a pop from an empty queue are both dropped.
// Assumes pop is a single-cycle request that is sampled on each clock.
module tx_word_queue
    import txq_pkg::*;
#(
    parameter int WORD_W = 31,
    parameter int BUS_W  = 16,
    parameter int DEPTH  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load_lo,
    input  logic                       load_hi,
    input  logic [BUS_W-1:0]           bus_data,
    input  logic                       pop,
    output logic [WORD_W-1:0]          head_word,
    output logic                       word_avail,
    output logic                       ready,
    output logic [cnt_bits(DEPTH)-1:0] word_count
);
    logic              lo_held;
    logic              commit_req;
    logic [WORD_W-1:0] commit_word;
    logic              q_empty;
    logic              q_full;
    logic              accept;
    logic              pop_fire;

    txq_assembler #(.WORD_W(WORD_W), .BUS_W(BUS_W)) u_asm (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_lo     (load_lo),
        .load_hi     (load_hi),
        .bus_data    (bus_data),
        .lo_held     (lo_held),
        .commit_req  (commit_req),
        .commit_word (commit_word)
    );

    // Gate the requests by occupancy so that neither overflow nor underflow occurs.
    always_comb begin
        accept   = commit_req && !q_full;
        pop_fire = pop && !q_empty;
    end

    txq_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (accept),
        .wr_word (commit_word),
        .rd_en   (pop_fire),
        .rd_word (head_word)
    );

    txq_count #(.DEPTH(DEPTH)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (accept),
        .dec   (pop_fire),
        .count (word_count),
        .empty (q_empty),
        .full  (q_full)
    );

    // Drive the flags seen by the host and the serializer.
    always_comb begin
        ready      = q_empty;
        word_avail = !q_empty;
    end
endmodule

// File: rtl/tx_word_queue_chk.sv
// Module: tx_word_queue_chk
// Property checker attached to tx_word_queue through bind. It relates the
// strobes, the pop and the outputs across clock edges.
// Assumes the same clock and reset as the queue.
module tx_word_queue_chk
    import txq_pkg::*;
#(
    parameter int WORD_W = 31,
    parameter int DEPTH  = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       load_hi,
    input logic                       pop,
    input logic                       lo_held,
    input logic [WORD_W-1:0]          head_word,
    input logic                       word_avail,
    input logic                       ready,
    input logic [cnt_bits(DEPTH)-1:0] word_count
);
    localparam int CNT_W = cnt_bits(DEPTH);

    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        word_count <= CNT_W'(DEPTH));

    a_r4_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (word_count == CNT_W'(DEPTH) && !pop) |=> (word_count == CNT_W'(DEPTH)));

    a_r5_orphan_high: assert property (@(posedge clk) disable iff (!rst_n)
        (load_hi && !lo_held && !pop) |=> $stable(word_count));

    a_r7_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !load_hi) |=> ready);

    a_r8_pop_and_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && load_hi && lo_held && word_avail && word_count != CNT_W'(DEPTH))
        |=> $stable(word_count));

    a_r10_avail_inverse: assert property (@(posedge clk) disable iff (!rst_n)
        word_avail != ready);

    a_r10_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (word_avail && !pop) |=> $stable(head_word));
endmodule

bind tx_word_queue tx_word_queue_chk #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_hi    (load_hi),
    .pop        (pop),
    .lo_held    (lo_held),
    .head_word  (head_word),
    .word_avail (word_avail),
    .ready      (ready),
    .word_count (word_count)
);

// File: tb/tx_word_queue_tb.sv
// Bench for tx_word_queue: directed corner cases followed by seeded random
// strobes and pops. A reference queue kept here is compared every cycle.
module tx_word_queue_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_lo = 1'b0;
    logic        load_hi = 1'b0;
    logic [15:0] bus_data = '0;
    logic        pop = 1'b0;
    logic [30:0] head_word;
    logic        word_avail;
    logic        ready;
    logic [3:0]  word_count;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    logic [30:0] mq[$];
    logic [15:0] m_lo = '0;
    bit          m_lo_valid = 0;

    tx_word_queue u_dut (
        .clk(clk), .rst_n(rst_n), .load_lo(load_lo), .load_hi(load_hi),
        .bus_data(bus_data), .pop(pop), .head_word(head_word),
        .word_avail(word_avail), .ready(ready), .word_count(word_count)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Expected word from the two bus values (R2 mapping).
    function automatic logic [30:0] build_word(input logic [15:0] lo, input logic [15:0] hi);
        return {hi[14:0], lo};
    endfunction

    // Compare every output with the reference queue.
    task automatic check_all(input string tag);
        chk(tag, "word_count", 32'(word_count), 32'(mq.size()));
        chk(tag, "ready", 32'(ready), 32'(mq.size() == 0));
        chk(tag, "word_avail", 32'(word_avail), 32'(mq.size() != 0));
        if (mq.size() != 0) chk(tag, "head_word", 32'(head_word), 32'(mq[0]));
    endtask

    // Drive one cycle at a falling edge, update the reference, check at the next falling edge.
    task automatic step(input logic lo, input logic hi, input logic p,
                        input logic [15:0] d, input string tag);
        bit m_commit, m_full, m_pop;
        load_lo = lo; load_hi = hi; pop = p; bus_data = d;
        m_commit = hi && m_lo_valid;
        m_full   = (mq.size() == 8);
        m_pop    = p && (mq.size() != 0);
        if (m_pop) void'(mq.pop_front());
        if (m_commit && !m_full) mq.push_back(build_word(m_lo, d));
        if (lo) begin m_lo = d; m_lo_valid = 1; end
        else if (hi) m_lo_valid = 0;
        @(negedge clk);
        load_lo = 0; load_hi = 0; pop = 0;
        check_all(tag);
    endtask

    task automatic put_word(input logic [15:0] lo, input logic [15:0] hi, input string tag);
        step(1, 0, 0, lo, tag);
        step(0, 1, 0, hi, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        check_all("R1");
        chk("R1", "head_word reset", 32'(head_word), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 R5: high strobe right after reset is ignored
        step(0, 1, 0, 16'h1234, "R5");
        // R2 R6: bit 15 of the high part dropped; ready falls after the commit
        put_word(16'hA5C3, 16'hFFFF, "R2");
        chk("R6", "ready after commit", 32'(ready), 32'h0);
        // R5: second high strobe after a commit is ignored
        step(0, 1, 0, 16'h0F0F, "R5");
        // R9: last low strobe wins
        step(1, 0, 0, 16'h1111, "R9");
        step(1, 0, 0, 16'h2222, "R9");
        step(0, 1, 0, 16'h0003, "R9");
        chk("R9", "word_count", 32'(word_count), 32'd2);
        // R3 R8: pop together with a commit
        step(1, 0, 0, 16'h3333, "R8");
        step(0, 1, 1, 16'h0044, "R8");
        chk("R8", "word_count same", 32'(word_count), 32'd2);
        // R4: fill to eight, then a ninth commit is dropped
        for (int i = 0; i < 6; i++) put_word(16'(i * 16'h0101), 16'(i + 16'h0010), "R4");
        chk("R4", "full count", 32'(word_count), 32'd8);
        put_word(16'hDEAD, 16'h7EEF, "R4");
        chk("R4", "count after ninth", 32'(word_count), 32'd8);
        // R3 R6: drain in order; ready rises after the last pop
        for (int i = 0; i < 8; i++) step(0, 0, 1, 16'h0, "R3");
        chk("R6", "ready after drain", 32'(ready), 32'h1);
        // R7: pop on empty is ignored
        step(0, 0, 1, 16'h0, "R7");
        chk("R7", "count after empty pop", 32'(word_count), 32'd0);
        // R9: both strobes in one cycle pair high with the prior low part
        step(1, 0, 0, 16'h5555, "R9");
        step(1, 1, 0, 16'h0066, "R9");
        step(0, 1, 0, 16'h0077, "R9");
        // R3 R7 R8 R10: random mix
        for (int i = 0; i < 3000; i++) begin
            int r;
            logic lo, hi, p;
            r  = $urandom_range(0, 9);
            lo = (r < 3) || (r == 9);
            hi = (r >= 3 && r < 6) || (r == 9);
            p  = ($urandom_range(0, 2) == 0);
            step(lo, hi, p, 16'($urandom), "R7");
        end
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule